// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up/Down Timer Counter

This block is a 16-bit timer counter that software reaches through an 8-bit register bus. Any read or write of the whole 16-bit value is atomic, even though it takes two bus accesses. A shared 8-bit holding register carries the upper byte between the two accesses. Reading the low byte captures the upper byte into the holding register. Writing the low byte commits the holding register and the bus byte into the counter in a single clock.

Each enabled tick makes the counter step up, step down or clear to zero. A small mode controller decides which. In the wrapping mode the counter runs upward through the full 16-bit range. In the up/down mode it climbs to a programmable limit, turns around and descends to zero. An internal prescaler turns a 3-bit clock-select field into a one-cycle tick enable. A sticky overflow flag drives an interrupt line.

The two terminal conditions are available on dedicated outputs:
- `top_hit`: the counter equals the active limit.
- `bottom_hit`: the counter equals zero.

Top module: `tick_count16`

## Requirements
- R1: A read of address 2 returns counter bits [7:0]. In the same clock it copies counter bits [15:8] into the holding register. A read of address 3 returns the holding register, so a low-then-high read pair returns one coherent 16-bit value.
- R2: A write to address 3 loads only the holding register and leaves the counter unchanged. A write to address 2 loads the counter with {holding register, write data} in one clock.
- R3: A counter write (address 2) in the same cycle as a tick wins. That tick has no other effect: it does not step the counter, does not set the overflow flag and does not change the count direction.
- R4: Address 0 bits [2:0] form the clock select:
  - 0 gives no ticks and clears the prescaler.
  - 1 gives a tick every cycle.
  - 2, 3, 4 and 5 give one tick every 8, 64, 256 and 1024 cycles of prescaler count.
  - 6 and 7 give no ticks.
  - The counter stays readable and writable while stopped.
- R5: With address 0 bit 3 = 0 (wrapping mode), every tick increments the counter. A tick at 0xFFFF wraps it to 0x0000 and sets the overflow flag.
- R6: With address 0 bit 3 = 1 (up/down mode), a tick behaves as follows:
  - At zero, it sets the overflow flag and turns the direction upward, incrementing the counter (or holding it at zero when the limit is 0).
  - At or above the limit, it turns the direction downward and decrements the counter.
  - Otherwise, it steps the counter in the current direction.
- R7: The overflow flag is bit 0 of address 1 and drives `ovf_irq`:
  - Writing 1 to that bit clears the flag.
  - Writing 0 leaves it unchanged.
  - A set event in the same cycle as a clear wins.
- R8: `top_hit` is high when the counter equals 0xFFFF in wrapping mode, or equals the limit in up/down mode. `bottom_hit` is high when the counter is zero.
- R9: Register map and reset values:
  - Address 0 reads back {0000, mode, select}.
  - Addresses 4 and 5 hold limit bits [7:0] and [15:8] and read back directly.
  - Unmapped addresses read 0.
  - Reset clears all registers to zero, except the limit, which resets to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ovf_irq | output | 1 | Sticky overflow flag / interrupt request |
| top_hit | output | 1 | Counter equals active limit |
| bottom_hit | output | 1 | Counter equals zero |

## Verification
The hardest situation to reach is a counter write landing in exactly the same cycle as a tick at a turning point. Examples are a write during the tick at 0xFFFF in wrapping mode, or at zero in up/down mode. Such a tick must be swallowed whole, and the overflow flag and direction must both be left unchanged.

The stimulus reaches this in two ways. It runs with clock select 1, so every cycle is a tick. It then steers the counter to the boundary with holding-register preloads and small limits. Random writes of near-boundary counter values are interleaved with mode flips and flag clears. A cycle-accurate bench model predicts every read and every output bit.

// File: rtl/tc16_pkg.sv
package tc16_pkg;

   // Register addresses; the counter low/high pair order matters for the
   // atomic access protocol.
   localparam int ADR_CTRL = 0;
   localparam int ADR_FLAG = 1;
   localparam int ADR_CNTL = 2;
   localparam int ADR_CNTH = 3;
   localparam int ADR_LIML = 4;
   localparam int ADR_LIMH = 5;

   typedef enum logic {
      MODE_WRAP   = 1'b0,
      MODE_UPDOWN = 1'b1
   } cnt_mode_e;

   // One step command from the mode controller to the datapath
   typedef struct packed {
      logic clear;
      logic count;
      logic down;
   } step_t;

endpackage

// File: rtl/tc16_prescale.sv
module tc16_prescale #(
   parameter int PRE_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   output logic       tick
);

   localparam int NTAP = 4;
   localparam int TAP_SH [NTAP] = '{3, 6, 8, 10};

   if (PRE_W < 10) begin : g_bad_pre
      $error("tc16_prescale: PRE_W must be at least 10");
   end

   logic [PRE_W-1:0] pre_q;
   logic [NTAP-1:0]  tap_hit;

   for (genvar g = 0; g < NTAP; g++) begin : g_tap
      assign tap_hit[g] = &pre_q[TAP_SH[g]-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (sel == 3'd0)
         pre_q <= '0;
      else
         pre_q <= pre_q + PRE_W'(1);
   end

   always_comb begin
      case (sel)
         3'd1:    tick = 1'b1;
         3'd2:    tick = tap_hit[0];
         3'd3:    tick = tap_hit[1];
         3'd4:    tick = tap_hit[2];
         3'd5:    tick = tap_hit[3];
         default: tick = 1'b0;
      endcase
   end

   // R4
   stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 3'd0) |-> !tick);

   // R4
   divided_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel >= 3'd2 && sel <= 3'd5) |=> (!tick || sel == 3'd1));

endmodule

// File: rtl/tc16_mode_ctl.sv
module tc16_mode_ctl
   import tc16_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hold,
   input  cnt_mode_e        mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] limit,
   output step_t            step,
   output logic             ovf_evt,
   output logic             at_top,
   output logic             at_bottom
);

   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   logic             dir_q;
   logic             dir_nxt;
   logic             apply;
   step_t            raw;
   logic             raw_ovf;
   logic [CNT_W-1:0] active_lim;

   assign apply      = tick && !hold;
   assign active_lim = (mode == MODE_UPDOWN) ? limit : ALL_ONES;
   assign at_top     = (cnt == active_lim);
   assign at_bottom  = (cnt == '0);

   always_comb begin
      raw     = '{clear: 1'b0, count: 1'b1, down: 1'b0};
      raw_ovf = 1'b0;
      dir_nxt = 1'b0;
      if (mode == MODE_WRAP) begin
         raw_ovf = (cnt == ALL_ONES);
      end else if (cnt == '0) begin
         raw_ovf   = 1'b1;
         raw.clear = (limit == '0);
         raw.count = (limit != '0);
      end else if (cnt >= limit) begin
         dir_nxt  = 1'b1;
         raw.down = 1'b1;
      end else begin
         dir_nxt  = dir_q;
         raw.down = dir_q;
      end
   end

   assign step    = apply ? raw : '{clear: 1'b0, count: 1'b0, down: 1'b0};
   assign ovf_evt = apply && raw_ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dir_q <= 1'b0;
      else if (apply)
         dir_q <= dir_nxt;
   end

   // R3
   write_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(dir_q));

   // R6
   bottom_turns_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && mode == MODE_UPDOWN && cnt == '0) |=> (dir_q == 1'b0));

endmodule

// File: rtl/tc16_count_core.sv
module tc16_count_core
   import tc16_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              rd_lo,
   input  logic [DATA_W-1:0] wdata,
   input  step_t             step,
   output logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] temp
);

   if (CNT_W != 2 * DATA_W) begin : g_bad_w
      $error("tc16_count_core: CNT_W must be twice DATA_W");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] temp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (wr_lo)
         cnt_q <= {temp_q, wdata};
      else if (step.clear)
         cnt_q <= '0;
      else if (step.count)
         cnt_q <= step.down ? cnt_q - CNT_W'(1) : cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         temp_q <= '0;
      else if (wr_hi)
         temp_q <= wdata;
      else if (rd_lo)
         temp_q <= cnt_q[CNT_W-1:DATA_W];
   end

   assign cnt  = cnt_q;
   assign temp = temp_q;

   // R2
   low_write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (cnt_q == {$past(temp_q), $past(wdata)}));

   // R1
   low_read_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !wr_hi) |=> (temp_q == $past(cnt_q[CNT_W-1:DATA_W])));

endmodule

// File: rtl/tick_count16.sv
module tick_count16
   import tc16_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ovf_irq,
   output logic              top_hit,
   output logic              bottom_hit
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADR_FLAG);
   localparam logic [ADDR_W-1:0] A_CNTL = ADDR_W'(ADR_CNTL);
   localparam logic [ADDR_W-1:0] A_CNTH = ADDR_W'(ADR_CNTH);
   localparam logic [ADDR_W-1:0] A_LIML = ADDR_W'(ADR_LIML);
   localparam logic [ADDR_W-1:0] A_LIMH = ADDR_W'(ADR_LIMH);

   if (ADDR_W < 3) begin : g_bad_a
      $error("tick_count16: ADDR_W must be at least 3");
   end
   if (DATA_W < 4) begin : g_bad_d
      $error("tick_count16: DATA_W must be at least 4");
   end

   logic [2:0]        cs_q;
   cnt_mode_e         mode_q;
   logic [CNT_W-1:0]  lim_q;
   logic              ovf_q;
   logic              tick;
   logic              wr_lo, wr_hi, rd_lo, wr_flag;
   step_t             step;
   logic              ovf_evt;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] temp;

   assign wr_lo   = bus_wr && (bus_addr == A_CNTL);
   assign wr_hi   = bus_wr && (bus_addr == A_CNTH);
   assign rd_lo   = bus_rd && (bus_addr == A_CNTL);
   assign wr_flag = bus_wr && (bus_addr == A_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 3'd0;
         mode_q <= MODE_WRAP;
         lim_q  <= '1;
      end else if (bus_wr) begin
         if (bus_addr == A_CTRL) begin
            cs_q   <= bus_wdata[2:0];
            mode_q <= cnt_mode_e'(bus_wdata[3]);
         end
         if (bus_addr == A_LIML) lim_q[DATA_W-1:0]     <= bus_wdata;
         if (bus_addr == A_LIMH) lim_q[CNT_W-1:DATA_W] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf_q <= 1'b0;
      else if (ovf_evt)
         ovf_q <= 1'b1;
      else if (wr_flag && bus_wdata[0])
         ovf_q <= 1'b0;
   end

   tc16_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (cs_q),
      .tick  (tick)
   );

   tc16_mode_ctl #(.CNT_W(CNT_W)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .hold      (wr_lo),
      .mode      (mode_q),
      .cnt       (cnt),
      .limit     (lim_q),
      .step      (step),
      .ovf_evt   (ovf_evt),
      .at_top    (top_hit),
      .at_bottom (bottom_hit)
   );

   tc16_count_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (wr_lo),
      .wr_hi (wr_hi),
      .rd_lo (rd_lo),
      .wdata (bus_wdata),
      .step  (step),
      .cnt   (cnt),
      .temp  (temp)
   );

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = {{(DATA_W-4){1'b0}}, mode_q, cs_q};
         A_FLAG:  bus_rdata = {{(DATA_W-1){1'b0}}, ovf_q};
         A_CNTL:  bus_rdata = cnt[DATA_W-1:0];
         A_CNTH:  bus_rdata = temp;
         A_LIML:  bus_rdata = lim_q[DATA_W-1:0];
         A_LIMH:  bus_rdata = lim_q[CNT_W-1:DATA_W];
         default: bus_rdata = '0;
      endcase
   end

   assign ovf_irq = ovf_q;

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !(wr_flag && bus_wdata[0])) |=> ovf_q);

   // R5
   wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_lo && mode_q == MODE_WRAP && cnt == '1) |=> (cnt == '0 && ovf_q));

   // R4
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q == 3'd0 && !wr_lo) |=> $stable(cnt));

endmodule

// File: tb/sim_tick_count16.sv
module sim_tick_count16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] b_addr = '0;
   logic       b_wr = 1'b0;
   logic       b_rd = 1'b0;
   logic [7:0] b_wdata = '0;
   logic [7:0] b_rdata;
   logic       irq, top_h, bot_h;

   int n_vec = 0;
   int n_bad = 0;
   logic started = 1'b0;

   // model state
   logic [15:0] m_cnt, m_lim;
   logic [7:0]  m_temp;
   logic        m_dir, m_ovf, m_mode;
   logic [2:0]  m_cs;
   logic [9:0]  m_p;

   tick_count16 u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (b_addr),
      .bus_wr     (b_wr),
      .bus_rd     (b_rd),
      .bus_wdata  (b_wdata),
      .bus_rdata  (b_rdata),
      .ovf_irq    (irq),
      .top_hit    (top_h),
      .bottom_hit (bot_h)
   );

   always #10 clk = ~clk;

   function automatic logic f_tick(input logic [2:0] cs, input logic [9:0] p);
      case (cs)
         3'd1: return 1'b1;
         3'd2: return &p[2:0];
         3'd3: return &p[5:0];
         3'd4: return &p[7:0];
         3'd5: return &p[9:0];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] f_read(input logic [2:0] a);
      case (a)
         3'd0: return {4'b0, m_mode, m_cs};
         3'd1: return {7'b0, m_ovf};
         3'd2: return m_cnt[7:0];
         3'd3: return m_temp;
         3'd4: return m_lim[7:0];
         3'd5: return m_lim[15:8];
         default: return 8'h00;
      endcase
   endfunction

   // cycle-accurate reference from the requirements
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_lim = 16'hFFFF; m_temp = 0; m_dir = 0; m_ovf = 0;
         m_mode = 0; m_cs = 0; m_p = 0;
      end else begin
         logic tk, set_o, wl;
         logic [15:0] nc;
         logic nd;
         tk = f_tick(m_cs, m_p);
         wl = b_wr && b_addr == 3'd2;
         nc = m_cnt; nd = m_dir; set_o = 0;
         if (wl) nc = {m_temp, b_wdata};
         else if (tk) begin
            if (!m_mode) begin
               set_o = (m_cnt == 16'hFFFF); nc = m_cnt + 16'd1; nd = 0;
            end else if (m_cnt == 0) begin
               set_o = 1; nd = 0; nc = (m_lim == 0) ? 16'd0 : 16'd1;
            end else if (m_cnt >= m_lim) begin
               nd = 1; nc = m_cnt - 16'd1;
            end else nc = m_dir ? m_cnt - 16'd1 : m_cnt + 16'd1;
         end
         if (b_wr && b_addr == 3'd3) m_temp = b_wdata;
         else if (b_rd && b_addr == 3'd2) m_temp = m_cnt[15:8];
         if (set_o) m_ovf = 1;
         else if (b_wr && b_addr == 3'd1 && b_wdata[0]) m_ovf = 0;
         m_p = (m_cs == 0) ? 10'd0 : m_p + 10'd1;
         if (b_wr && b_addr == 3'd0) begin m_cs = b_wdata[2:0]; m_mode = b_wdata[3]; end
         if (b_wr && b_addr == 3'd4) m_lim[7:0] = b_wdata;
         if (b_wr && b_addr == 3'd5) m_lim[15:8] = b_wdata;
         m_cnt = nc; m_dir = nd;
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle output checks
   always @(negedge clk) begin
      if (started && rst_n) begin
         logic [15:0] lim;
         lim = m_mode ? m_lim : 16'hFFFF;
         chk("R8 top_hit", {15'b0, top_h}, {15'b0, m_cnt == lim});
         chk("R8 bottom_hit", {15'b0, bot_h}, {15'b0, m_cnt == 0});
         chk("R7 ovf_irq", {15'b0, irq}, {15'b0, m_ovf});
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      b_addr = a; b_wdata = d; b_wr = 1'b1;
      @(negedge clk);
      b_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input string req);
      b_addr = a; b_rd = 1'b1;
      #1;
      chk(req, {8'b0, b_rdata}, {8'b0, f_read(a)});
      @(negedge clk);
      b_rd = 1'b0;
   endtask

   task automatic rd16(input string req);
      rd(3'd2, req);
      rd(3'd3, req);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put16(input logic [15:0] v);
      wr(3'd3, v[15:8]);
      wr(3'd2, v[7:0]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      started = 1'b1;

      // R9 reset state
      for (int a = 0; a < 8; a++) rd(3'(a), "R9 reset");
      chk("R9 reset irq", {15'b0, irq}, 16'd0);

      // R2 high write alone leaves counter untouched
      wr(3'd3, 8'h12);
      rd(3'd3, "R2 holding");
      rd16("R2 untouched");
      chk("R2 counter zero", {8'b0, b_rdata}, 16'h0000);
      put16(16'hABCD);
      rd16("R2 atomic write");
      chk("R1 coherent high", {8'b0, b_rdata}, 16'h00AB);

      // R4 stopped counter still writable
      idle(20);
      rd16("R4 stopped");

      // R5 wrap with flag
      put16(16'hFFFD);
      wr(3'd0, 8'h01);
      idle(4);
      wr(3'd0, 8'h00);
      rd16("R5 wrapped");
      rd(3'd1, "R5 flag");
      // R7 write-0 keeps, write-1 clears
      wr(3'd1, 8'hFE);
      rd(3'd1, "R7 write zero");
      wr(3'd1, 8'h01);
      rd(3'd1, "R7 write one");

      // R3 write collides with wrapping tick
      put16(16'hFFFE);
      wr(3'd0, 8'h01);
      wr(3'd3, 8'h44);
      wr(3'd2, 8'h55);
      wr(3'd0, 8'h00);
      rd16("R3 collision");
      rd(3'd1, "R3 no flag");

      // R4 divided ticks
      for (int s = 2; s <= 7; s++) begin
         put16(16'h0000);
         wr(3'd0, 8'(s));
         idle(300);
         wr(3'd0, 8'h00);
         rd16("R4 prescale");
      end

      // R6 up/down with small limit
      wr(3'd4, 8'h05); wr(3'd5, 8'h00);
      put16(16'h0000);
      wr(3'd1, 8'h01);
      wr(3'd0, 8'h09);
      idle(17);
      wr(3'd0, 8'h08);
      rd16("R6 updown");
      rd(3'd1, "R6 flag");
      // R6 zero limit holds at zero
      wr(3'd4, 8'h00);
      wr(3'd0, 8'h09);
      idle(6);
      wr(3'd0, 8'h08);
      rd16("R6 zero limit");

      // randomized traffic
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom % 12;
         case (r)
            0, 1, 2: rd(3'($urandom % 8), "R1 random read");
            3: wr(3'd0, {4'b0, 1'($urandom), 3'(($urandom % 4 == 0) ? 2 : 1)});
            4: wr(3'd3, ($urandom % 2) ? 8'hFF : 8'($urandom));
            5: wr(3'd2, 8'(($urandom % 2) ? 8'hFE + $urandom % 2 : $urandom));
            6: wr(3'd4, 8'($urandom % 24));
            7: wr(3'd5, ($urandom % 4 == 0) ? 8'($urandom) : 8'h00);
            8: wr(3'd1, 8'($urandom));
            9: wr(3'd3, 8'h00);
            default: idle(1 + $urandom % 4);
         endcase
      end
      rd16("R1 final");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule